// File: doc/BRIEF.md
# Soft-Ramping Per-Channel Audio Attenuator

This block scales a multi-channel stream of 24-bit two's-complement audio samples by a gain held separately for each channel. Each channel's gain is an 8-bit code on a linear amplitude scale. The top code gives unity gain. Code 0 gives silence. The codes in between give a gain of code/255, which reaches about -48 dB at code 1. The block sits in the sample path ahead of the interpolation and noise-shaping stages.

Software or a control block sets a target code for each channel. The block does not jump to a new target. On each valid sample the applied gain moves one code closer to the target, so level changes never produce an audible click. If the target moves while a ramp is running, the ramp turns toward the new value from wherever the gain stands at that moment. Each scaled sample appears one clock after its valid strobe. The output holds its value between strobes.

Top module: `soft_atten`

## Requirements
- R1: While reset is asserted, out_valid is 0 and every output sample is 0. The applied gain of every channel starts at code 255 (unity).
- R2: out_valid is 1 in exactly the cycle after a cycle with in_valid 1. When in_valid was 0 in the previous cycle, the output samples keep their previous value.
- R3: An output sample equals the input sample times gain/255, rounded to the nearest integer. Rounding is symmetric about zero: the magnitude is rounded and the sign is then restored.
- R4: At gain code 255 the sample passes unchanged. At gain code 0 the output is 0 (mute).
- R5: On each cycle with in_valid 1, the applied gain of a channel moves one code toward that channel's target. It stops when the two are equal. Without in_valid the gain does not change, even if the target changes.
- R6: A target change in the middle of a ramp redirects the ramp from the current gain. The ramp does not restart and does not jump.
- R7: Each channel's gain and target are independent of the other channels. Channel 0 occupies bits [23:0] of in_samp and out_samp and bits [7:0] of target. Channel 1 occupies the next field up in each.
- R8: The output stays inside the 24-bit signed range. -8388608 at unity gain comes out as -8388608, and +8388607 as +8388607.
- R9: A sample is scaled with the gain in force before the step taken on that same valid cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe marking a new sample on every channel |
| in_samp | input | 48 | Input samples, 24 bits per channel, channel 0 in the lowest field |
| target | input | 16 | Target gain codes, 8 bits per channel, channel 0 in the lowest field |
| out_valid | output | 1 | Strobe marking new output samples |
| out_samp | output | 48 | Scaled samples, 24 bits per channel, channel 0 in the lowest field |

## Verification
Two things can happen in the same valid cycle: a sample is scaled, and the gain takes a ramp step that may also be redirected by a new target. The bench drives a sample with in_valid on every cycle throughout the ramps. It also changes targets in the same cycles that samples arrive. Each output is checked against a bench model that applies the pre-step gain and only afterwards moves its own gain toward the target. A design that steps first, or that restarts the ramp on a new target, therefore shows a miscompare of one code's worth of scaling.

// File: rtl/soft_atten_pkg.sv
package soft_atten_pkg;
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/soft_atten_ramp.sv
module soft_atten_ramp #(
    parameter int CW       = 8,
    parameter int RST_CODE = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic [CW-1:0] target,
    output logic [CW-1:0] gain
);
    import soft_atten_pkg::*;

    typedef struct packed {
        logic [CW-1:0] gain;
    } ramp_st_t;

    ramp_st_t  st_d, st_q;
    ramp_dir_e dir;

    always_comb begin
        st_d = st_q;
        if (target > st_q.gain)      dir = RAMP_UP;
        else if (target < st_q.gain) dir = RAMP_DOWN;
        else                         dir = RAMP_HOLD;
        if (step_en) begin
            case (dir)
                RAMP_UP:   st_d.gain = st_q.gain + 1'b1;
                RAMP_DOWN: st_d.gain = st_q.gain - 1'b1;
                default:   st_d.gain = st_q.gain;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{gain: CW'(RST_CODE)};
        else        st_q <= st_d;
    end

    assign gain = st_q.gain;
endmodule

// File: rtl/soft_atten_scale.sv
module soft_atten_scale #(
    parameter int DW = 24,
    parameter int CW = 8
) (
    input  logic [DW-1:0] sample,
    input  logic [CW-1:0] gain,
    output logic [DW-1:0] scaled
);
    localparam int PW   = DW + CW + 1;
    localparam int FULL = (1 << CW) - 1;
    localparam int HALF = FULL / 2;
    localparam logic signed [PW:0] MAXP = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW:0] MINP = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};

    logic              neg;
    logic signed [DW:0] sx;
    logic [DW:0]       mag;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     quo;
    logic signed [PW:0] res_d;

    always_comb begin
        sx    = {sample[DW-1], sample};
        neg   = sample[DW-1];
        mag   = neg ? unsigned'(-sx) : unsigned'(sx);
        prod  = PW'(mag) * PW'(gain);
        quo   = (prod + PW'(HALF)) / PW'(FULL);
        res_d = neg ? -$signed({1'b0, quo}) : $signed({1'b0, quo});
        if (res_d > MAXP)      scaled = MAXP[DW-1:0];
        else if (res_d < MINP) scaled = MINP[DW-1:0];
        else                   scaled = res_d[DW-1:0];
    end
endmodule

// File: rtl/soft_atten.sv
module soft_atten #(
    parameter int NCH      = 2,
    parameter int DW       = 24,
    parameter int CW       = 8,
    parameter int RST_CODE = (1 << CW) - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [NCH-1:0][DW-1:0] in_samp,
    input  logic [NCH-1:0][CW-1:0] target,
    output logic                   out_valid,
    output logic [NCH-1:0][DW-1:0] out_samp
);
    typedef struct packed {
        logic                   valid;
        logic [NCH-1:0][DW-1:0] samp;
    } out_st_t;

    logic [NCH-1:0][CW-1:0] gain_q;
    logic [NCH-1:0][DW-1:0] scaled;
    out_st_t                st_d, st_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        soft_atten_ramp #(.CW(CW), .RST_CODE(RST_CODE)) u_ramp (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (in_valid),
            .target  (target[c]),
            .gain    (gain_q[c])
        );
        soft_atten_scale #(.DW(DW), .CW(CW)) u_scale (
            .sample (in_samp[c]),
            .gain   (gain_q[c]),
            .scaled (scaled[c])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.samp = scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_samp  = st_q.samp;
endmodule

// File: rtl/soft_atten_chk.sv
module soft_atten_chk #(
    parameter int NCH = 2,
    parameter int DW  = 24,
    parameter int CW  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [NCH-1:0][CW-1:0] target,
    input logic [NCH-1:0][CW-1:0] gain_q,
    input logic                   out_valid,
    input logic [NCH-1:0][DW-1:0] out_samp
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_samp));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(gain_q[c]));
        a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && gain_q[c] < target[c]) |=> gain_q[c] == $past(gain_q[c]) + 1'b1);
        a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && gain_q[c] > target[c]) |=> gain_q[c] == $past(gain_q[c]) - 1'b1);
        a_r5_settled: assert property (@(posedge clk) disable iff (!rst_n)
            (gain_q[c] == target[c]) |=> $stable(gain_q[c]) || target[c] != $past(target[c]) || gain_q[c] != $past(gain_q[c]) + 1'b1);
        a_r4_mute: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && gain_q[c] == '0) |=> out_samp[c] == '0);
    end
endmodule

bind soft_atten soft_atten_chk #(.NCH(NCH), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .target    (target),
    .gain_q    (gain_q),
    .out_valid (out_valid),
    .out_samp  (out_samp)
);

// File: tb/soft_atten_bench.sv
module soft_atten_bench;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0][23:0] in_samp = '0;
    logic [1:0][7:0]  target = {8'd255, 8'd255};
    logic             out_valid;
    logic [1:0][23:0] out_samp;

    int applied = 0;
    int miscmp  = 0;
    int gm [2];
    int last [2];
    bit done = 0;

    always #5 clk = ~clk;

    soft_atten u_soft_atten (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samp(in_samp),
        .target(target), .out_valid(out_valid), .out_samp(out_samp)
    );

    function automatic int expv(int s, int g);
        longint p = longint'(s) * g;
        longint q;
        if (p >= 0) q = (p + 127) / 255;
        else        q = -((-p + 127) / 255);
        return int'(q);
    endfunction

    function automatic int pseudo(int i, int salt);
        logic [31:0] h = (i + salt) * 32'h9E3779B1;
        return int'($signed(h[31:8]));
    endfunction

    task automatic check(string tag, int act, int exp);
        applied++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(string tag, int s0, int s1, int t0, int t1);
        int e [2];
        @(negedge clk);
        in_valid = 1'b1;
        in_samp  = {24'(s1), 24'(s0)};
        target   = {8'(t1), 8'(t0)};
        e[0] = expv(s0, gm[0]);
        e[1] = expv(s1, gm[1]);
        if (gm[0] < t0) gm[0]++; else if (gm[0] > t0) gm[0]--;
        if (gm[1] < t1) gm[1]++; else if (gm[1] > t1) gm[1]--;
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        check({tag, " R2 valid"}, int'(out_valid), 1);
        check({tag, " ch0"}, int'($signed(out_samp[0])), e[0]);
        check({tag, " ch1"}, int'($signed(out_samp[1])), e[1]);
        last[0] = e[0];
        last[1] = e[1];
    endtask

    task automatic idle(int n, int t0, int t1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_samp  = {24'(pseudo(k, 7)), 24'(pseudo(k, 3))};
            target   = {8'(t1), 8'(t0)};
            @(posedge clk);
            #2;
            check("R2 idle valid", int'(out_valid), 0);
            check("R2 hold ch0", int'($signed(out_samp[0])), last[0]);
            check("R2 hold ch1", int'($signed(out_samp[1])), last[1]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
            $finish;
        end
    end

    initial begin
        gm[0] = 255; gm[1] = 255;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset ch0", int'($signed(out_samp[0])), 0);
        check("R1 reset ch1", int'($signed(out_samp[1])), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R4 R8: unity right after reset, full-scale extremes
        send("R8 extremes", -8388608, 8388607, 255, 255);
        send("R4 unity", 8388607, -8388608, 255, 255);

        // R3 R5 R7 R9: full downward sweep of channel 0, channel 1 held
        for (int i = 0; i < 262; i++)
            send("R3 R9 sweep", pseudo(i, 11), pseudo(i, 29), 0, 255);
        send("R4 mute", 8388607, -8388608, 0, 255);

        // R5: no stepping without valid, even with a new target
        idle(6, 200, 30);
        send("R5 frozen", 8388607, 8388607, 200, 30);

        // R6: redirect mid-ramp, targets changing in the same cycles as samples
        for (int i = 0; i < 40; i++)
            send("R6 ramp", pseudo(i, 51), pseudo(i, 77), 200, 30);
        for (int i = 0; i < 60; i++)
            send("R6 redirect", pseudo(i, 91), -8388608, 10, 140);
        for (int i = 0; i < 20; i++)
            send("R7 mixed", -1 - i, 1 + i, (i * 37) % 256, 255 - i);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
        $finish;
    end
endmodule